// File: doc/BRIEF.md
# Evolution coprocessor command decoder with crossover mask generation

The block sits between a processor and a gene-processing pipeline. Software places 32-bit command words into a dual-ported command buffer and hands them to the decoder on a valid/ready stream. Each command is decoded from its low byte and then carried out. Value commands load one of five global parameter registers. Table commands copy a block of words from the buffer into one of six selector lookup tables. Mask commands turn run lengths or packed binary words into a serial crossover mask, one bit per gene. Transfer commands follow a pointer into a table held in the buffer and fetch a memory address and a gene count for the memory controller.

The buffer read port has a fixed one-cycle latency: the decoder drives `ib_rd_en` and `ib_addr`, and the word appears on `ib_rdata` in the next cycle. Mask bits pass through a small internal FIFO and leave on a valid/ready stream. Once `mask_valid` is high, `mask_bit` holds until `mask_ready` takes it. While the FIFO is full the decoder stops generating bits and takes no new command. Transfer commands leave on a second valid/ready stream. The address, length and kind hold until `xfer_ready`, and no command is accepted in the meantime. Parameter and table writes are single-cycle pulses with no back-pressure.

Top module: `evo_cmd_decoder`

## Requirements
- R1: A command is taken when `cmd_valid` and `cmd_ready` are both high. Its opcode is bits 7:0. `cmd_ready` is high only while the decoder is idle, and bits outside the fields a command uses are ignored.
- R2: Opcodes 0x07 to 0x0B write parameter select 0 to 4 (random maximum, fraction, constant, probability 1, probability 2) with the value in bits 23:8. `prm_we` pulses for one cycle, in the cycle after the command is taken.
- R3: Opcodes 0x01 to 0x06 read LUT_WORDS consecutive buffer words, starting at the buffer address in bits 18:8. Each word gives one `lut_we` pulse with `lut_sel` = opcode − 1, `lut_idx` counting from 0, and `lut_data` equal to the word.
- R4: Opcode 0x0E emits as many 0 mask bits as the count in bits 23:8, and opcode 0x0F emits as many 1 bits. A count of zero emits nothing.
- R5: Opcode 0x0D reads the number of words in bits 31:19, starting at the address in bits 18:8. Bits 15:0 of each word are a run length. The runs alternate in value starting with 0, and a zero-length run still switches the value.
- R6: Opcode 0x0C reads the words the same way and emits all 32 bits of each word, least significant bit first. A word count of zero for 0x0C or 0x0D emits nothing.
- R7: Opcodes 0x10, 0x11 and 0x12 (parent 1, parent 2, child) read the memory address at the buffer address in bits 18:8 and the gene count at the next location. They then present one transfer with `xfer_kind` 0, 1 or 2 respectively.
- R8: Opcode 0x00 and any opcode above 0x12 pulse `err_opcode` for one cycle and have no other effect. The next command is handled normally.
- R9: Mask bits leave in generation order. A bit held under back-pressure is stable. While the FIFO is full, generation pauses and `cmd_ready` stays low until the command's last bit is queued.
- R10: A transfer held under back-pressure keeps `xfer_valid`, kind, address and length stable, and `cmd_ready` stays low until it is taken.
- R11: After reset, `cmd_ready` is high and every valid, write-enable, read-enable and error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Decoder idle, command taken this cycle if valid |
| cmd_word | input | 32 | Command word |
| ib_rd_en | output | 1 | Buffer read request |
| ib_addr | output | IB_AW | Buffer read address |
| ib_rdata | input | 32 | Buffer read data, one cycle after the request |
| prm_we | output | 1 | Parameter write pulse |
| prm_sel | output | 3 | Parameter select 0..4 |
| prm_val | output | 16 | Parameter value |
| lut_we | output | 1 | Table word write pulse |
| lut_sel | output | 3 | Table select 0..5 |
| lut_idx | output | LIW | Word index within the table |
| lut_data | output | 32 | Table word |
| mask_valid | output | 1 | Mask bit available |
| mask_ready | input | 1 | Consumer takes mask bit |
| mask_bit | output | 1 | Mask bit (0 = parent 1, 1 = parent 2) |
| xfer_valid | output | 1 | Transfer command available |
| xfer_ready | input | 1 | Consumer takes transfer |
| xfer_kind | output | 2 | 0 parent 1, 1 parent 2, 2 child |
| xfer_addr | output | 32 | Memory address from the table |
| xfer_len | output | 32 | Gene count from the table |
| err_opcode | output | 1 | Unknown opcode pulse |

## Verification
The hardest state to reach is a full mask FIFO while a long run is still being generated. It only occurs when the consumer withholds `mask_ready` for longer than the FIFO depth. The bench therefore holds `mask_ready` low through a 20-bit run and checks that `cmd_ready` stays low and that no bit leaves. It then releases the stream and checks the complete bit order. The two-point run-length case (27, 51, 50) and a packed binary mask are then repeated under pseudo-random back-pressure on both output streams, so that stalls land at arbitrary points inside runs and words.

// File: rtl/evo_dec_pkg.sv
package evo_dec_pkg;
  localparam int INSTR_W = 32;

  localparam logic [7:0] OP_LUT_FIRST = 8'h01;
  localparam logic [7:0] OP_LUT_LAST  = 8'h06;
  localparam logic [7:0] OP_PRM_FIRST = 8'h07;
  localparam logic [7:0] OP_PRM_LAST  = 8'h0B;
  localparam logic [7:0] OP_MASK_BIN  = 8'h0C;
  localparam logic [7:0] OP_MASK_RL   = 8'h0D;
  localparam logic [7:0] OP_RUN_ZERO  = 8'h0E;
  localparam logic [7:0] OP_RUN_ONE   = 8'h0F;
  localparam logic [7:0] OP_XFER_P1   = 8'h10;
  localparam logic [7:0] OP_XFER_CH   = 8'h12;

  typedef enum logic [2:0] {
    K_BAD,
    K_LUT,
    K_PARAM,
    K_MASK_BIN,
    K_MASK_RL,
    K_RUN,
    K_XFER
  } cmd_cls_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_DATA,
    S_EMIT,
    S_XFER
  } dec_state_e;
endpackage

// File: rtl/evo_op_decode.sv
module evo_op_decode
  import evo_dec_pkg::*;
#(
  parameter int IB_AW = 11,
  parameter int CNT_W = 13,
  parameter int VAL_W = 16
) (
  input  logic [INSTR_W-1:0] word,
  output cmd_cls_e           cls,
  output logic [2:0]         sub,
  output logic [IB_AW-1:0]   addr,
  output logic [CNT_W-1:0]   count,
  output logic [VAL_W-1:0]   value
);
  logic [7:0] op;
  assign op    = word[7:0];
  assign addr  = word[8 +: IB_AW];
  assign count = word[19 +: CNT_W];
  assign value = word[8 +: VAL_W];

  always_comb begin
    cls = K_BAD;
    sub = '0;
    if (op >= OP_LUT_FIRST && op <= OP_LUT_LAST) begin
      cls = K_LUT;
      sub = 3'(op - OP_LUT_FIRST);
    end else if (op >= OP_PRM_FIRST && op <= OP_PRM_LAST) begin
      cls = K_PARAM;
      sub = 3'(op - OP_PRM_FIRST);
    end else if (op == OP_MASK_BIN) begin
      cls = K_MASK_BIN;
    end else if (op == OP_MASK_RL) begin
      cls = K_MASK_RL;
    end else if (op == OP_RUN_ZERO || op == OP_RUN_ONE) begin
      cls = K_RUN;
      sub = {2'b00, op[0]};
    end else if (op >= OP_XFER_P1 && op <= OP_XFER_CH) begin
      cls = K_XFER;
      sub = 3'(op - OP_XFER_P1);
    end
  end
endmodule

// File: rtl/evo_bit_emitter.sv
module evo_bit_emitter #(
  parameter int WORD_W = 32,
  parameter int RUN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              bin,
  input  logic              run_val,
  input  logic [RUN_W-1:0]  run_len,
  input  logic [WORD_W-1:0] word,
  input  logic              full,
  output logic              busy,
  output logic              push,
  output logic              push_bit
);
  localparam int CW = (RUN_W > $clog2(WORD_W + 1)) ? RUN_W : $clog2(WORD_W + 1);

  logic [CW-1:0]     rem;
  logic [WORD_W-1:0] sreg;
  logic              bin_q;
  logic              val_q;

  assign busy     = (rem != '0);
  assign push     = busy && !full;
  assign push_bit = bin_q ? sreg[0] : val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      sreg  <= '0;
      bin_q <= 1'b0;
      val_q <= 1'b0;
    end else if (load) begin
      rem   <= bin ? CW'(WORD_W) : CW'(run_len);
      sreg  <= word;
      bin_q <= bin;
      val_q <= run_val;
    end else if (push) begin
      rem  <= rem - 1'b1;
      sreg <= sreg >> 1;
    end
  end

  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/evo_bit_fifo.sv
module evo_bit_fifo #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic full,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             wr, rd;

  assign full      = (cnt == (AW+1)'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_bit   = mem[rp];
  assign wr        = in_valid && !full;
  assign rd        = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(wr) - (AW+1)'(rd);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));
endmodule

// File: rtl/evo_cmd_decoder.sv
module evo_cmd_decoder
  import evo_dec_pkg::*;
#(
  parameter int IB_AW      = 11,
  parameter int LUT_WORDS  = 8,
  parameter int MASK_DEPTH = 8,
  parameter int CNT_W      = 13,
  parameter int VAL_W      = 16,
  localparam int LIW       = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [INSTR_W-1:0] cmd_word,
  output logic               ib_rd_en,
  output logic [IB_AW-1:0]   ib_addr,
  input  logic [INSTR_W-1:0] ib_rdata,
  output logic               prm_we,
  output logic [2:0]         prm_sel,
  output logic [VAL_W-1:0]   prm_val,
  output logic               lut_we,
  output logic [2:0]         lut_sel,
  output logic [LIW-1:0]     lut_idx,
  output logic [INSTR_W-1:0] lut_data,
  output logic               mask_valid,
  input  logic               mask_ready,
  output logic               mask_bit,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [1:0]         xfer_kind,
  output logic [INSTR_W-1:0] xfer_addr,
  output logic [INSTR_W-1:0] xfer_len,
  output logic               err_opcode
);
  localparam int RUN_W = 16;

  cmd_cls_e         dec_cls;
  logic [2:0]       dec_sub;
  logic [IB_AW-1:0] dec_addr;
  logic [CNT_W-1:0] dec_count;
  logic [VAL_W-1:0] dec_value;

  dec_state_e       state;
  cmd_cls_e         cls_q;
  logic [2:0]       sub_q;
  logic [IB_AW-1:0] ptr;
  logic [CNT_W-1:0] words_left;
  logic [LIW-1:0]   lut_cnt;
  logic             rl_val;
  logic             accept;

  logic             em_load, em_bin, em_val, em_busy, em_push, em_bit;
  logic [RUN_W-1:0] em_len;
  logic             fifo_full;

  evo_op_decode #(.IB_AW(IB_AW), .CNT_W(CNT_W), .VAL_W(VAL_W)) u_dec (
    .word(cmd_word), .cls(dec_cls), .sub(dec_sub),
    .addr(dec_addr), .count(dec_count), .value(dec_value)
  );

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign ib_rd_en  = (state == S_RD);
  assign ib_addr   = ptr;

  always_comb begin
    em_load = 1'b0;
    em_bin  = 1'b0;
    em_val  = 1'b0;
    em_len  = '0;
    if (accept && dec_cls == K_RUN) begin
      em_load = 1'b1;
      em_val  = dec_sub[0];
      em_len  = RUN_W'(dec_value);
    end else if (state == S_DATA && (cls_q == K_MASK_BIN || cls_q == K_MASK_RL)) begin
      em_load = 1'b1;
      em_bin  = (cls_q == K_MASK_BIN);
      em_val  = rl_val;
      em_len  = ib_rdata[RUN_W-1:0];
    end
  end

  evo_bit_emitter #(.WORD_W(INSTR_W), .RUN_W(RUN_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(em_load), .bin(em_bin), .run_val(em_val),
    .run_len(em_len), .word(ib_rdata), .full(fifo_full),
    .busy(em_busy), .push(em_push), .push_bit(em_bit)
  );

  evo_bit_fifo #(.DEPTH(MASK_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(em_push), .in_bit(em_bit),
    .full(fifo_full), .out_valid(mask_valid), .out_ready(mask_ready),
    .out_bit(mask_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cls_q      <= K_BAD;
      sub_q      <= '0;
      ptr        <= '0;
      words_left <= '0;
      lut_cnt    <= '0;
      rl_val     <= 1'b0;
      prm_we     <= 1'b0;
      prm_sel    <= '0;
      prm_val    <= '0;
      lut_we     <= 1'b0;
      lut_sel    <= '0;
      lut_idx    <= '0;
      lut_data   <= '0;
      xfer_valid <= 1'b0;
      xfer_kind  <= '0;
      xfer_addr  <= '0;
      xfer_len   <= '0;
      err_opcode <= 1'b0;
    end else begin
      prm_we     <= 1'b0;
      lut_we     <= 1'b0;
      err_opcode <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          cls_q  <= dec_cls;
          sub_q  <= dec_sub;
          ptr    <= dec_addr;
          rl_val <= 1'b0;
          case (dec_cls)
            K_PARAM: begin
              prm_we  <= 1'b1;
              prm_sel <= dec_sub;
              prm_val <= dec_value;
            end
            K_RUN: state <= S_EMIT;
            K_LUT: begin
              words_left <= CNT_W'(LUT_WORDS);
              lut_cnt    <= '0;
              state      <= S_RD;
            end
            K_MASK_BIN, K_MASK_RL: begin
              words_left <= dec_count;
              state      <= (dec_count == '0) ? S_IDLE : S_RD;
            end
            K_XFER: begin
              words_left <= CNT_W'(2);
              state      <= S_RD;
            end
            default: err_opcode <= 1'b1;
          endcase
        end
        S_RD: state <= S_DATA;
        S_DATA: begin
          ptr        <= ptr + 1'b1;
          words_left <= words_left - 1'b1;
          case (cls_q)
            K_LUT: begin
              lut_we   <= 1'b1;
              lut_sel  <= sub_q;
              lut_idx  <= lut_cnt;
              lut_data <= ib_rdata;
              lut_cnt  <= lut_cnt + 1'b1;
              state    <= (words_left == CNT_W'(1)) ? S_IDLE : S_RD;
            end
            K_MASK_BIN: state <= S_EMIT;
            K_MASK_RL: begin
              rl_val <= ~rl_val;
              state  <= S_EMIT;
            end
            K_XFER: begin
              if (words_left == CNT_W'(2)) begin
                xfer_addr <= ib_rdata;
                state     <= S_RD;
              end else begin
                xfer_len   <= ib_rdata;
                xfer_kind  <= sub_q[1:0];
                xfer_valid <= 1'b1;
                state      <= S_XFER;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
        S_EMIT: if (!em_busy) begin
          state <= (cls_q == K_RUN || words_left == '0) ? S_IDLE : S_RD;
        end
        S_XFER: if (xfer_ready) begin
          xfer_valid <= 1'b0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr)
      && $stable(xfer_len) && $stable(xfer_kind));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    em_busy |-> !cmd_ready);

  // R3
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ib_rd_en |-> !cmd_ready);

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prm_we, lut_we, err_opcode}));

  // R2
  prm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prm_we |-> $past(cmd_valid && cmd_ready));
endmodule

// File: tb/tb_evo_cmd_decoder.sv
module tb_evo_cmd_decoder;
  localparam int IB_AW = 11;
  localparam int LUT_WORDS = 8;
  localparam int LIW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [31:0] cmd_word = '0;
  logic ib_rd_en;
  logic [IB_AW-1:0] ib_addr;
  logic [31:0] ib_rdata = '0;
  logic prm_we, lut_we, mask_valid, mask_bit, xfer_valid, err_opcode;
  logic [2:0] prm_sel, lut_sel;
  logic [15:0] prm_val;
  logic [LIW-1:0] lut_idx;
  logic [31:0] lut_data, xfer_addr, xfer_len;
  logic [1:0] xfer_kind;
  logic mask_ready = 1'b1;
  logic xfer_ready = 1'b1;

  evo_cmd_decoder #(.IB_AW(IB_AW), .LUT_WORDS(LUT_WORDS), .MASK_DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .ib_rd_en(ib_rd_en), .ib_addr(ib_addr), .ib_rdata(ib_rdata),
    .prm_we(prm_we), .prm_sel(prm_sel), .prm_val(prm_val),
    .lut_we(lut_we), .lut_sel(lut_sel), .lut_idx(lut_idx), .lut_data(lut_data),
    .mask_valid(mask_valid), .mask_ready(mask_ready), .mask_bit(mask_bit),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_kind(xfer_kind),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .err_opcode(err_opcode)
  );

  always #10 clk = ~clk;

  logic [31:0] ibm [0:(1<<IB_AW)-1];
  always @(posedge clk) if (ib_rd_en) ib_rdata <= ibm[ib_addr];

  int n_chk = 0;
  int n_fail = 0;
  int n_err = 0;
  bit done = 0;
  int mr_mode = 0;
  int xr_mode = 0;
  logic [15:0] lf = 16'hACE1;

  bit          got_bits[$];
  bit          exp_bits[$];
  logic [18:0] prm_q[$];
  logic [37:0] lut_q[$];
  logic [65:0] xf_q[$];

  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    mask_ready = (mr_mode == 0) ? 1'b1 : (mr_mode == 1) ? lf[0] : 1'b0;
    xfer_ready = (xr_mode == 0) ? 1'b1 : (xr_mode == 1) ? lf[3] : 1'b0;
    #1;
    if (rst_n) begin
      if (mask_valid && mask_ready) got_bits.push_back(mask_bit);
      if (xfer_valid && xfer_ready) xf_q.push_back({xfer_kind, xfer_addr, xfer_len});
      if (prm_we) prm_q.push_back({prm_sel, prm_val});
      if (lut_we) lut_q.push_back({lut_sel, lut_idx, lut_data});
      if (err_opcode) n_err++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (!cmd_ready || mask_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_bits(input string tag);
    chk(got_bits.size() == exp_bits.size(), {tag, " bit count"}, got_bits.size(), exp_bits.size());
    for (int i = 0; i < got_bits.size() && i < exp_bits.size(); i++)
      chk(got_bits[i] == exp_bits[i], {tag, " bit"}, got_bits[i], exp_bits[i]);
    got_bits.delete();
    exp_bits.delete();
  endtask

  task automatic add_run(input bit v, input int n);
    for (int i = 0; i < n; i++) exp_bits.push_back(v);
  endtask

  task automatic rl_test(input string tag);
    ibm[300] = 32'hF00D_001B;
    ibm[301] = 32'h0000_0033;
    ibm[302] = 32'h1234_0032;
    send({13'd3, 11'd300, 8'h0D});
    settle();
    add_run(1'b0, 27); add_run(1'b1, 51); add_run(1'b0, 50);
    cmp_bits(tag);
  endtask

  task automatic bin_test(input string tag);
    ibm[400] = 32'hDEAD_BEEF;
    ibm[401] = 32'h0000_8001;
    send({13'd2, 11'd400, 8'h0C});
    settle();
    for (int k = 0; k < 2; k++)
      for (int b = 0; b < 32; b++) exp_bits.push_back(ibm[400 + k][b]);
    cmp_bits(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R1 watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << IB_AW); i++) ibm[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
    chk({mask_valid, xfer_valid, prm_we, lut_we, err_opcode, ib_rd_en} == 6'b0,
        "R11 idle outputs", {mask_valid, xfer_valid, prm_we, lut_we, err_opcode, ib_rd_en}, 0);

    // R2 and R1: parameter writes, high byte junk ignored
    for (int s = 0; s < 5; s++)
      for (int j = 0; j < 3; j++) begin
        logic [15:0] v;
        v = (j == 0) ? 16'h0000 : (j == 1) ? 16'hFFFF : 16'(16'h1234 + s * 16'h0111);
        send({8'hA5, v, 8'(8'h07 + s)});
        settle();
        chk(prm_q.size() == 1, "R2 one write", prm_q.size(), 1);
        if (prm_q.size() != 0) begin
          chk(prm_q[0] == {3'(s), v}, "R2 sel/value", prm_q[0], {3'(s), v});
          prm_q.delete();
        end
      end

    // R3: table loads from buffer, R1 ready low while reading
    for (int op = 1; op <= 6; op++) begin
      int base;
      base = 100 + op * 16;
      for (int k = 0; k < LUT_WORDS; k++)
        ibm[base + k] = {8'(op), 8'(k), 16'(16'hC3A0 ^ (op * 37 + k))};
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = {13'h1ABC, 11'(base), 8'(op)};
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R1 busy after table cmd", cmd_ready, 0);
      settle();
      chk(lut_q.size() == LUT_WORDS, "R3 word count", lut_q.size(), LUT_WORDS);
      for (int k = 0; k < lut_q.size() && k < LUT_WORDS; k++)
        chk(lut_q[k] == {3'(op - 1), 3'(k), ibm[base + k]}, "R3 table word",
            lut_q[k], {3'(op - 1), 3'(k), ibm[base + k]});
      lut_q.delete();
    end

    // R4: sweep of direct runs of both values, lengths 0..20, plus a long one
    for (int v = 0; v < 2; v++)
      for (int n = 0; n <= 20; n++) begin
        send({8'h00, 16'(n), 8'(8'h0E + v)});
        add_run(v[0], n);
      end
    send({8'hFF, 16'd300, 8'h0F});
    add_run(1'b1, 300);
    settle();
    cmp_bits("R4");

    // R5: two-point crossover runs and zero-length toggles
    rl_test("R5");
    ibm[310] = 32'hFFFF_0000;
    ibm[311] = 32'h0000_0005;
    ibm[312] = 32'h0000_0000;
    ibm[313] = 32'h0000_0003;
    send({13'd4, 11'd310, 8'h0D});
    settle();
    add_run(1'b1, 8);
    cmp_bits("R5 zero runs");

    // R6: packed binary words, then zero word counts
    bin_test("R6");
    send({13'd0, 11'd400, 8'h0C});
    send({13'd0, 11'd300, 8'h0D});
    settle();
    cmp_bits("R6 zero count");

    // R7: transfers from pointer table
    ibm[500] = 32'h1000_0040; ibm[501] = 32'd128;
    ibm[510] = 32'hCAFE_0000; ibm[511] = 32'd7;
    send({13'h0, 11'd500, 8'h10});
    send({13'h0, 11'd510, 8'h11});
    send({13'h0, 11'd500, 8'h12});
    settle();
    chk(xf_q.size() == 3, "R7 transfer count", xf_q.size(), 3);
    if (xf_q.size() == 3) begin
      chk(xf_q[0] == {2'd0, 32'h1000_0040, 32'd128}, "R7 parent1", xf_q[0], {2'd0, 32'h1000_0040, 32'd128});
      chk(xf_q[1] == {2'd1, 32'hCAFE_0000, 32'd7}, "R7 parent2", xf_q[1], {2'd1, 32'hCAFE_0000, 32'd7});
      chk(xf_q[2] == {2'd2, 32'h1000_0040, 32'd128}, "R7 child", xf_q[2], {2'd2, 32'h1000_0040, 32'd128});
    end
    xf_q.delete();

    // R8: unknown opcodes skipped, next command still works
    n_err = 0;
    send(32'h0000_0100);
    send(32'h0001_0013);
    send(32'h0000_007F);
    send(32'hFFFF_FFFF);
    send({8'h00, 16'h5A5A, 8'h09});
    settle();
    chk(n_err == 4, "R8 error pulses", n_err, 4);
    chk(lut_q.size() + xf_q.size() + got_bits.size() == 0, "R8 no side effect",
        lut_q.size() + xf_q.size() + got_bits.size(), 0);
    chk(prm_q.size() == 1 && prm_q[0] == {3'd2, 16'h5A5A}, "R8 next command",
        prm_q.size() ? prm_q[0] : 19'h0, {3'd2, 16'h5A5A});
    prm_q.delete();

    // R9: FIFO full stalls the decoder
    mr_mode = 2;
    send({8'h00, 16'd20, 8'h0F});
    repeat (30) @(negedge clk);
    chk(cmd_ready == 1'b0, "R9 stalled while full", cmd_ready, 0);
    chk(got_bits.size() == 0, "R9 nothing taken", got_bits.size(), 0);
    mr_mode = 0;
    settle();
    add_run(1'b1, 20);
    cmp_bits("R9 after release");

    // R9: random back-pressure on mask stream
    mr_mode = 1;
    rl_test("R9 rl stalls");
    bin_test("R9 bin stalls");
    mr_mode = 0;

    // R10: transfer held
    xr_mode = 2;
    send({13'h0, 11'd510, 8'h12});
    repeat (10) @(negedge clk);
    chk(xfer_valid == 1'b1, "R10 valid held", xfer_valid, 1);
    chk(cmd_ready == 1'b0, "R10 no new command", cmd_ready, 0);
    chk({xfer_kind, xfer_addr, xfer_len} == {2'd2, 32'hCAFE_0000, 32'd7}, "R10 fields",
        {xfer_kind, xfer_addr, xfer_len}, {2'd2, 32'hCAFE_0000, 32'd7});
    xr_mode = 1;
    settle();
    send({13'h0, 11'd500, 8'h11});
    settle();
    xr_mode = 0;
    chk(xf_q.size() == 2, "R10 transfer count", xf_q.size(), 2);
    if (xf_q.size() == 2)
      chk(xf_q[1] == {2'd1, 32'h1000_0040, 32'd128}, "R10 random ready", xf_q[1],
          {2'd1, 32'h1000_0040, 32'd128});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule